// File: doc/BRIEF.md
# Cascadable Dual Timer with Capture and PWM

This block holds two 8-bit counting channels that share one register write port. Each channel counts ticks from a clock enable. The ticks come from a prescaler outside the block, or, on channel 0, from rising edges of an external event input. In a split mode each channel compares its count with its own data register and toggles its output on a match. Either channel can instead latch its count when a capture strobe rises. The two channels can be chained into one 16-bit counter that compares or captures as a single unit. Channel 1 can also become a 10-bit PWM generator while channel 0 keeps running as an 8-bit timer.

The operating mode is a small state machine with five states:

- `MODE_SPLIT8`: two 8-bit timers.
- `MODE_SPLITCAP`: 8-bit channels, at least one of them capturing.
- `MODE_WIDE16`: one 16-bit timer.
- `MODE_WIDECAP`: one 16-bit capture unit.
- `MODE_PWM10`: channel 1 makes PWM.

The state holds (`stay`) until either control register is written. On that write the `decode` transition picks the new state from the written fields. Cascade takes precedence over PWM, and PWM takes precedence over the split modes. Capture strobes and the event input each pass through a two-flop synchronizer and a rising-edge detector. Status flags are sticky, and software clears them by writing 1s.

Register map (address: content):

- 0: control 0. Bits [2:0] select the clock (111 selects the event input, any other code selects the prescale enable). Bit 3 enables capture, bit 4 requests cascade and bit 5 enables the pin.
- 1: control 1. Bits [1:0] select the clock (11 selects channel 0's tick, any other code selects channel 1's own enable). Bit 3 enables capture, bit 4 enables PWM and bit 5 enables the pin.
- 2: data 0.
- 3: data 1.
- 4: PWM period, low byte.
- 5: PWM duty, low byte.
- 6: PWM high bits. Bits [1:0] are the upper period bits and bits [3:2] are the upper duty bits.
- 7: flag clear, write 1 to clear. Bit 0 is match 0, bit 1 is match 1, bit 2 is capture 0 and bit 3 is capture 1.

Top module: `dual_timer_pwm`

## Requirements
- R1: While reset is held, both timer outputs, both pin enables, all four flags and both capture values are 0.
- R2: In a split mode with capture off, a channel tick while the count equals the data register sets the count to 0 and toggles that channel's output. Any other tick adds 1, so the output period is data+1 ticks per level.
- R3: Each compare match sets its sticky flag: bit 0 for channel 0 or 16-bit matches, bit 1 for channel 1 or PWM period ends.
- R4: Writing address 7 clears each flag whose data bit is 1. A flag that is set in the same cycle as its clear stays 1.
- R5: With channel 1 select 11, channel 1 counts channel 0's ticks and ignores its own enable. With select 00, it counts only its own enable.
- R6: With channel 0 select 111, channel 0 counts one tick per synchronized rising edge of the event input and ignores its prescale enable.
- R7: With cascade bit set and channel 1 select 11, the pair counts as one 16-bit value on channel 0 ticks, compares against {data1,data0}, toggles output 0 and sets flag bit 0.
- R8: Each pin enable output follows bit 5 of its control register.
- R9: With capture enabled on a channel, compare is off. The channel's capture value takes the count present in the third clock edge after the strobe rises; a tick in that same cycle does not affect the captured value. Flag bit 2 or bit 3 is then set.
- R10: In 16-bit capture mode (cascade, select 11, control 0 bit 3), a strobe 0 edge writes count bits [7:0] to capture 0 and bits [15:8] to capture 1 in one cycle.
- R11: In PWM mode, output 1 is high while the 10-bit count is below the 10-bit duty. A tick at count equal to the period returns the count to 0 and sets flag bit 1.
- R12: The PWM period and duty are 10 bits: address 6 bits [1:0] above the period byte, bits [3:2] above the duty byte.
- R13: Writing a control register clears that channel's count and output; in 16-bit modes either write clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_en0 | input | 1 | Prescaled count enable, channel 0 |
| presc_en1 | input | 1 | Prescaled count enable, channel 1 |
| ext_evt | input | 1 | External event clock, asynchronous |
| cap_in0 | input | 1 | Capture strobe 0, asynchronous |
| cap_in1 | input | 1 | Capture strobe 1, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pin_oe0 | output | 1 | Pin override enable, channel 0 |
| pin_oe1 | output | 1 | Pin override enable, channel 1 |
| tmr_out0 | output | 1 | Timer output level, channel 0 |
| tmr_out1 | output | 1 | Timer or PWM output level, channel 1 |
| irq_flags | output | 4 | Sticky match and capture flags |
| cap_val0 | output | 8 | Capture register 0 |
| cap_val1 | output | 8 | Capture register 1 |

## Verification
Two pairs of functions can collide in the same cycle. The first pair is a compare match that sets flag bit 0 and a write that clears it. The bench sets data 0 to 0, so every tick matches, then drives a tick together with the clear write and expects the flag to read 1. A separate clear alone must then bring it to 0. The second pair is a capture strobe and a count tick: the bench places a prescale pulse exactly on the capture edge and expects the pre-increment count in the capture register, then the incremented count on a later capture.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
    localparam int ADDR_W = 3;
    localparam int NFLAG  = 4;

    localparam logic [ADDR_W-1:0] A_CTRL0 = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL1 = 3'd1;
    localparam logic [ADDR_W-1:0] A_DATA0 = 3'd2;
    localparam logic [ADDR_W-1:0] A_DATA1 = 3'd3;
    localparam logic [ADDR_W-1:0] A_PERLO = 3'd4;
    localparam logic [ADDR_W-1:0] A_DUTLO = 3'd5;
    localparam logic [ADDR_W-1:0] A_PWMHI = 3'd6;
    localparam logic [ADDR_W-1:0] A_FCLR  = 3'd7;

    typedef enum logic [2:0] {
        MODE_SPLIT8   = 3'd0,
        MODE_SPLITCAP = 3'd1,
        MODE_WIDE16   = 3'd2,
        MODE_WIDECAP  = 3'd3,
        MODE_PWM10    = 3'd4
    } mode_e;
endpackage

// File: rtl/dtp_sync_edge.sv
module dtp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], d};
    end

    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    // one tick per edge, whether it feeds capture or event counting (R6)
    assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/dtp_regs_fsm.sv
module dtp_regs_fsm
    import dtp_pkg::*;
#(
    parameter int CW  = 8,
    parameter int PHI = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic [NFLAG-1:0]  flag_set,
    output logic [2:0]        sel0,
    output logic              cap_en0,
    output logic              pin0,
    output logic [1:0]        sel1,
    output logic              cap_en1,
    output logic              pin1,
    output logic [CW-1:0]     data0,
    output logic [CW-1:0]     data1,
    output logic [CW-1:0]     per_lo,
    output logic [CW-1:0]     duty_lo,
    output logic [2*PHI-1:0]  pwm_hi,
    output logic [NFLAG-1:0]  flags,
    output logic              clr0,
    output logic              clr1,
    output mode_e             mode
);
    // c0: {pin, cascade, capture, sel[2:0]}   c1: {pin, pwm, capture, sel[1:0]}
    logic [5:0]       c0_q, c0_n;
    logic [4:0]       c1_q, c1_n;
    logic [NFLAG-1:0] clr_mask;
    mode_e            mode_q, mode_d;

    assign clr0     = wr_en && (wr_addr == A_CTRL0);
    assign clr1     = wr_en && (wr_addr == A_CTRL1);
    assign clr_mask = (wr_en && (wr_addr == A_FCLR)) ? wr_data[NFLAG-1:0] : '0;
    assign c0_n     = clr0 ? wr_data[5:0] : c0_q;
    assign c1_n     = clr1 ? {wr_data[5:3], wr_data[1:0]} : c1_q;

    // next-state: stay unless a control register is written, then decode
    always_comb begin
        mode_d = mode_q;
        if (clr0 || clr1) begin
            if (c0_n[4] && (c1_n[1:0] == 2'b11))
                mode_d = c0_n[3] ? MODE_WIDECAP : MODE_WIDE16;
            else if (c1_n[3])
                mode_d = MODE_PWM10;
            else if (c0_n[3] || c1_n[2])
                mode_d = MODE_SPLITCAP;
            else
                mode_d = MODE_SPLIT8;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_SPLIT8;
        else        mode_q <= mode_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c0_q    <= '0;
            c1_q    <= '0;
            data0   <= '0;
            data1   <= '0;
            per_lo  <= '0;
            duty_lo <= '0;
            pwm_hi  <= '0;
            flags   <= '0;
        end else begin
            c0_q  <= c0_n;
            c1_q  <= c1_n;
            flags <= (flags & ~clr_mask) | flag_set;
            if (wr_en) begin
                unique case (wr_addr)
                    A_DATA0: data0   <= wr_data;
                    A_DATA1: data1   <= wr_data;
                    A_PERLO: per_lo  <= wr_data;
                    A_DUTLO: duty_lo <= wr_data;
                    A_PWMHI: pwm_hi  <= wr_data[2*PHI-1:0];
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        mode    = mode_q;
        sel0    = c0_q[2:0];
        cap_en0 = c0_q[3];
        pin0    = c0_q[5];
        sel1    = c1_q[1:0];
        cap_en1 = c1_q[2];
        pin1    = c1_q[4];
    end

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set[0] |=> flags[0]);
    assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask[0] && !flag_set[0]) |=> !flags[0]);
endmodule

// File: rtl/dtp_count_core.sv
module dtp_count_core
    import dtp_pkg::*;
#(
    parameter int CW  = 8,
    parameter int PHI = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode,
    input  logic [2:0]       sel0,
    input  logic             cap_en0,
    input  logic [1:0]       sel1,
    input  logic             cap_en1,
    input  logic [CW-1:0]    data0,
    input  logic [CW-1:0]    data1,
    input  logic [CW-1:0]    per_lo,
    input  logic [CW-1:0]    duty_lo,
    input  logic [2*PHI-1:0] pwm_hi,
    input  logic             clr0,
    input  logic             clr1,
    input  logic             presc_en0,
    input  logic             presc_en1,
    input  logic             ext_rise,
    input  logic             cap_rise0,
    input  logic             cap_rise1,
    output logic             out0,
    output logic             out1,
    output logic [CW-1:0]    cap0,
    output logic [CW-1:0]    cap1,
    output logic [NFLAG-1:0] flag_set
);
    localparam int PW = CW + PHI;

    logic [CW-1:0]  cnt0_q, cnt0_d, cnt1_q, cnt1_d, cap0_d, cap1_d;
    logic [PHI-1:0] hi1_q, hi1_d;
    logic           tog0_q, tog0_d, tog1_q, tog1_d;
    logic           tick0, tick1, wide;
    logic [2*CW-1:0] wide_cnt, wide_cmp;
    logic [PW-1:0]  pwm_cnt, period, duty;

    assign tick0    = (sel0 == 3'b111) ? ext_rise : presc_en0;
    assign tick1    = (sel1 == 2'b11) ? tick0 : presc_en1;
    assign wide     = (mode == MODE_WIDE16) || (mode == MODE_WIDECAP);
    assign wide_cnt = {cnt1_q, cnt0_q};
    assign wide_cmp = {data1, data0};
    assign pwm_cnt  = {hi1_q, cnt1_q};
    assign period   = {pwm_hi[PHI-1:0], per_lo};
    assign duty     = {pwm_hi[2*PHI-1:PHI], duty_lo};

    always_comb begin
        cnt0_d   = cnt0_q;
        cnt1_d   = cnt1_q;
        hi1_d    = hi1_q;
        tog0_d   = tog0_q;
        tog1_d   = tog1_q;
        cap0_d   = cap0;
        cap1_d   = cap1;
        flag_set = '0;
        unique case (mode)
            MODE_WIDE16, MODE_WIDECAP: begin
                hi1_d = '0;
                if (clr0 || clr1) begin
                    {cnt1_d, cnt0_d} = '0;
                    tog0_d = 1'b0;
                    tog1_d = 1'b0;
                end else if (tick0) begin
                    if ((mode == MODE_WIDE16) && (wide_cnt == wide_cmp)) begin
                        {cnt1_d, cnt0_d} = '0;
                        tog0_d      = ~tog0_q;
                        flag_set[0] = 1'b1;
                    end else begin
                        {cnt1_d, cnt0_d} = wide_cnt + 1'b1;
                    end
                end
                if ((mode == MODE_WIDECAP) && cap_rise0) begin
                    cap0_d      = cnt0_q;
                    cap1_d      = cnt1_q;
                    flag_set[2] = 1'b1;
                end
            end
            default: begin
                // channel 0, always 8-bit here
                if (clr0) begin
                    cnt0_d = '0;
                    tog0_d = 1'b0;
                end else if (tick0) begin
                    if (!cap_en0 && (cnt0_q == data0)) begin
                        cnt0_d      = '0;
                        tog0_d      = ~tog0_q;
                        flag_set[0] = 1'b1;
                    end else begin
                        cnt0_d = cnt0_q + 1'b1;
                    end
                end
                if (cap_en0 && cap_rise0) begin
                    cap0_d      = cnt0_q;
                    flag_set[2] = 1'b1;
                end
                // channel 1: PWM or 8-bit
                if (mode == MODE_PWM10) begin
                    if (clr1) begin
                        {hi1_d, cnt1_d} = '0;
                    end else if (tick1) begin
                        if (pwm_cnt == period) begin
                            {hi1_d, cnt1_d} = '0;
                            flag_set[1]     = 1'b1;
                        end else begin
                            {hi1_d, cnt1_d} = pwm_cnt + 1'b1;
                        end
                    end
                end else begin
                    hi1_d = '0;
                    if (clr1) begin
                        cnt1_d = '0;
                        tog1_d = 1'b0;
                    end else if (tick1) begin
                        if (!cap_en1 && (cnt1_q == data1)) begin
                            cnt1_d      = '0;
                            tog1_d      = ~tog1_q;
                            flag_set[1] = 1'b1;
                        end else begin
                            cnt1_d = cnt1_q + 1'b1;
                        end
                    end
                    if (cap_en1 && cap_rise1) begin
                        cap1_d      = cnt1_q;
                        flag_set[3] = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt0_q <= '0;
            cnt1_q <= '0;
            hi1_q  <= '0;
            tog0_q <= 1'b0;
            tog1_q <= 1'b0;
            cap0   <= '0;
            cap1   <= '0;
        end else begin
            cnt0_q <= cnt0_d;
            cnt1_q <= cnt1_d;
            hi1_q  <= hi1_d;
            tog0_q <= tog0_d;
            tog1_q <= tog1_d;
            cap0   <= cap0_d;
            cap1   <= cap1_d;
        end
    end

    assign out0 = tog0_q;
    assign out1 = (mode == MODE_PWM10) ? (pwm_cnt < duty) : tog1_q;

    assert_match_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && !clr0 && tick0 && !cap_en0 && (cnt0_q == data0))
        |=> (cnt0_q == '0) && (tog0_q != $past(tog0_q)));
    assert_wide_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_WIDECAP) && !clr0 && !clr1 && tick0 && (cnt0_q == '1))
        |=> (cnt1_q == $past(cnt1_q) + 1'b1) && (cnt0_q == '0));
    assert_capture_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && cap_en0 && cap_rise0) |=> (cap0 == $past(cnt0_q)));
    assert_wide_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_WIDECAP) && cap_rise0)
        |=> (cap0 == $past(cnt0_q)) && (cap1 == $past(cnt1_q)));
    assert_pwm_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_PWM10) && !clr1 && tick1 && (pwm_cnt == period))
        |=> (pwm_cnt == '0));
    assert_ctrl_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && clr0) |=> (cnt0_q == '0) && !tog0_q);
endmodule

// File: rtl/dual_timer_pwm.sv
module dual_timer_pwm
    import dtp_pkg::*;
#(
    parameter int CW   = 8,
    parameter int PHI  = 2,
    parameter int SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              presc_en0,
    input  logic              presc_en1,
    input  logic              ext_evt,
    input  logic              cap_in0,
    input  logic              cap_in1,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    output logic              pin_oe0,
    output logic              pin_oe1,
    output logic              tmr_out0,
    output logic              tmr_out1,
    output logic [NFLAG-1:0]  irq_flags,
    output logic [CW-1:0]     cap_val0,
    output logic [CW-1:0]     cap_val1
);
    localparam int NSTROBE = 3;

    logic [NSTROBE-1:0] raw_in, rise_v;
    logic [2:0]         sel0;
    logic [1:0]         sel1;
    logic               cap_en0, cap_en1, clr0, clr1;
    logic [CW-1:0]      data0, data1, per_lo, duty_lo;
    logic [2*PHI-1:0]   pwm_hi;
    logic [NFLAG-1:0]   flag_set;
    mode_e              mode;

    assign raw_in = {ext_evt, cap_in1, cap_in0};

    for (genvar g = 0; g < NSTROBE; g++) begin : g_sync
        dtp_sync_edge #(.STAGES(SYNC)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw_in[g]),
            .rise (rise_v[g])
        );
    end

    dtp_regs_fsm #(.CW(CW), .PHI(PHI)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .flag_set(flag_set),
        .sel0    (sel0),
        .cap_en0 (cap_en0),
        .pin0    (pin_oe0),
        .sel1    (sel1),
        .cap_en1 (cap_en1),
        .pin1    (pin_oe1),
        .data0   (data0),
        .data1   (data1),
        .per_lo  (per_lo),
        .duty_lo (duty_lo),
        .pwm_hi  (pwm_hi),
        .flags   (irq_flags),
        .clr0    (clr0),
        .clr1    (clr1),
        .mode    (mode)
    );

    dtp_count_core #(.CW(CW), .PHI(PHI)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .sel0     (sel0),
        .cap_en0  (cap_en0),
        .sel1     (sel1),
        .cap_en1  (cap_en1),
        .data0    (data0),
        .data1    (data1),
        .per_lo   (per_lo),
        .duty_lo  (duty_lo),
        .pwm_hi   (pwm_hi),
        .clr0     (clr0),
        .clr1     (clr1),
        .presc_en0(presc_en0),
        .presc_en1(presc_en1),
        .ext_rise (rise_v[2]),
        .cap_rise0(rise_v[0]),
        .cap_rise1(rise_v[1]),
        .out0     (tmr_out0),
        .out1     (tmr_out1),
        .cap0     (cap_val0),
        .cap1     (cap_val1),
        .flag_set (flag_set)
    );
endmodule

// File: tb/test_dual_timer_pwm.sv
module test_dual_timer_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       presc_en0 = 1'b0, presc_en1 = 1'b0, ext_evt = 1'b0;
    logic       cap_in0 = 1'b0, cap_in1 = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pin_oe0, pin_oe1, tmr_out0, tmr_out1;
    logic [3:0] irq_flags;
    logic [7:0] cap_val0, cap_val1;

    always #5 clk = ~clk;

    dual_timer_pwm i_dual_timer_pwm (
        .clk(clk), .rst_n(rst_n), .presc_en0(presc_en0), .presc_en1(presc_en1),
        .ext_evt(ext_evt), .cap_in0(cap_in0), .cap_in1(cap_in1),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pin_oe0(pin_oe0), .pin_oe1(pin_oe1), .tmr_out0(tmr_out0), .tmr_out1(tmr_out1),
        .irq_flags(irq_flags), .cap_val0(cap_val0), .cap_val1(cap_val1));

    typedef struct {
        string       req;
        int          sel;
        logic [15:0] exp;
    } item_t;

    item_t q[$];
    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;

    function automatic logic [15:0] observe(int sel);
        case (sel)
            0:       return 16'(tmr_out0);
            1:       return 16'(tmr_out1);
            2:       return 16'(irq_flags);
            3:       return 16'(cap_val0);
            4:       return 16'(cap_val1);
            default: return 16'({pin_oe1, pin_oe0});
        endcase
    endfunction

    // monitor: compares queued expectations against the outputs mid-cycle
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t       it;
            logic [15:0] act;
            it  = q.pop_front();
            act = observe(it.sel);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic expect_item(string req, int sel, logic [15:0] exp);
        item_t it;
        it.req = req;
        it.sel = sel;
        it.exp = exp;
        q.push_back(it);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse0(int n);
        for (int i = 0; i < n; i++) begin
            presc_en0 = 1'b1; step(); presc_en0 = 1'b0; step();
        end
    endtask

    task automatic pulse1(int n);
        for (int i = 0; i < n; i++) begin
            presc_en1 = 1'b1; step(); presc_en1 = 1'b0; step();
        end
    endtask

    task automatic ext_pulse();
        ext_evt = 1'b1;
        repeat (4) step();
        ext_evt = 1'b0;
        repeat (4) step();
    endtask

    // capture lands on the third edge after the strobe rises
    task automatic strobe0(bit with_tick);
        cap_in0 = 1'b1;
        step();
        step();
        if (with_tick) presc_en0 = 1'b1;
        step();
        presc_en0 = 1'b0;
        cap_in0 = 1'b0;
        repeat (4) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        // R1 reset values
        expect_item("R1 out0", 0, 0);
        expect_item("R1 out1", 1, 0);
        expect_item("R1 flags", 2, 0);
        expect_item("R1 cap0", 3, 0);
        expect_item("R1 cap1", 4, 0);
        expect_item("R1 pins", 5, 0);
        step();
        rst_n = 1'b1;
        step();

        // R2/R3/R8 split compare on channel 0, data 3
        wr(3'd2, 8'd3);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h20);
        wr(3'd7, 8'h0F);
        pulse0(3);
        expect_item("R2 no toggle before match", 0, 0);
        expect_item("R3 no flag before match", 2, 0);
        pulse0(1);
        expect_item("R2 toggle on match", 0, 1);
        expect_item("R3 match flag", 2, 4'b0001);
        expect_item("R8 pin enable 0", 5, 2'b01);
        pulse0(4);
        expect_item("R2 second period toggles back", 0, 0);
        pulse0(4);
        wr(3'd0, 8'h20);
        expect_item("R13 ctrl write clears output", 0, 0);
        wr(3'd7, 8'h01);
        expect_item("R4 write-one clear", 2, 0);

        // R5 channel 1 clock source
        wr(3'd2, 8'd200);
        wr(3'd3, 8'd1);
        wr(3'd1, 8'h03);
        pulse1(2);
        expect_item("R5 own enable ignored with select 11", 1, 0);
        pulse0(2);
        expect_item("R5 follows channel 0 ticks", 1, 1);
        wr(3'd1, 8'h00);
        pulse0(2);
        expect_item("R5 channel 0 ticks ignored with select 00", 1, 0);
        pulse1(2);
        expect_item("R5 own enable counts", 1, 1);

        // R6 external event counting
        wr(3'd1, 8'h00);
        wr(3'd2, 8'd1);
        wr(3'd0, 8'h07);
        wr(3'd7, 8'h0F);
        pulse0(3);
        expect_item("R6 prescale ignored", 0, 0);
        expect_item("R6 no flag from prescale", 2, 0);
        ext_pulse();
        expect_item("R6 one event", 0, 0);
        ext_pulse();
        expect_item("R6 second event matches", 0, 1);

        // R7 16-bit compare at 0x0102
        wr(3'd2, 8'd2);
        wr(3'd3, 8'd1);
        wr(3'd1, 8'h03);
        wr(3'd0, 8'h10);
        wr(3'd7, 8'h0F);
        pulse0(258);
        expect_item("R7 no match at 258 ticks", 0, 0);
        expect_item("R7 no flag at 258 ticks", 2, 0);
        pulse0(1);
        expect_item("R7 16-bit match toggles", 0, 1);
        expect_item("R7 16-bit match flag", 2, 4'b0001);

        // R9 8-bit capture with same-cycle tick
        wr(3'd1, 8'h00);
        wr(3'd2, 8'd2);
        wr(3'd0, 8'h08);
        wr(3'd7, 8'h0F);
        pulse0(5);
        expect_item("R9 compare off in capture", 0, 0);
        expect_item("R9 no match flag in capture", 2, 0);
        strobe0(1'b1);
        expect_item("R9 pre-tick count captured", 3, 8'd5);
        expect_item("R9 capture flag", 2, 4'b0100);
        strobe0(1'b0);
        expect_item("R9 tick had advanced count", 3, 8'd6);

        // R10 16-bit capture of 300
        wr(3'd1, 8'h03);
        wr(3'd0, 8'h18);
        wr(3'd7, 8'h0F);
        pulse0(300);
        strobe0(1'b0);
        expect_item("R10 low byte", 3, 8'h2C);
        expect_item("R10 high byte", 4, 8'h01);
        expect_item("R10 capture flag", 2, 4'b0100);

        // R11 PWM period 9 duty 3
        wr(3'd4, 8'd9);
        wr(3'd5, 8'd3);
        wr(3'd6, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h30);
        wr(3'd7, 8'h0F);
        expect_item("R11 high at count 0", 1, 1);
        expect_item("R8 pin enable 1", 5, 2'b10);
        pulse1(3);
        expect_item("R11 low at duty", 1, 0);
        pulse1(6);
        expect_item("R11 low at period", 1, 0);
        expect_item("R11 no flag before wrap", 2, 0);
        pulse1(1);
        expect_item("R11 high after wrap", 1, 1);
        expect_item("R11 period flag", 2, 4'b0010);

        // R12 high bits: period 256, duty 256
        wr(3'd4, 8'd0);
        wr(3'd5, 8'd0);
        wr(3'd6, 8'h05);
        wr(3'd1, 8'h30);
        pulse1(255);
        expect_item("R12 high at 255", 1, 1);
        pulse1(1);
        expect_item("R12 low at 256", 1, 0);
        pulse1(1);
        expect_item("R12 wraps after 256", 1, 1);

        // R4 set and clear in the same cycle
        wr(3'd1, 8'h00);
        wr(3'd2, 8'd0);
        wr(3'd0, 8'h00);
        wr(3'd7, 8'h0F);
        wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'h01; presc_en0 = 1'b1;
        step();
        wr_en = 1'b0; presc_en0 = 1'b0;
        expect_item("R4 set wins over clear", 2, 4'b0001);
        wr(3'd7, 8'h01);
        expect_item("R4 clear alone", 2, 0);

        step();
        step();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule